// File: doc/BRIEF.md
# Strap-Selected Boot Download Sequencer

After reset, this block picks a boot mode from three strap inputs. It then copies program words from a slow, synchronous-read source memory into a program RAM, one word per cycle. The words are placed according to header words that are stored in the source itself. When no copy remains, it raises a one-cycle handoff pulse so that the processor can start the loaded code.

In debugger mode the source is a dual-ported mailbox that a host filled earlier. It holds a single header of word count and destination address at a fixed base, and the code follows at once. In EPROM mode the source is a boot EPROM holding a chain of segments. Each segment is a control word, a count, a destination and then the code, and a flag in the control word says whether another segment follows. While an EPROM load is in progress, a status output marks that program-space reads are served by the EPROM.

Top module: `strap_boot_loader`

## Requirements
- R1: The straps are sampled once, at the first rising edge with `rst` low. Strap changes after that edge have no effect on any output until the next reset.
- R2: Mode decode. Load and debug both high selects debugger mode, whatever the EPROM strap is. Load and EPROM high with debug low selects EPROM mode. Any other combination gives no mode: handoff is high in the first cycle after the sampling edge, with no source read and no RAM write.
- R3: In debugger mode the count is read from mailbox address 0xF400, the destination from 0xF401, and code words from 0xF402 upward. `rom_rd_en` stays low.
- R4: In EPROM mode the first segment starts at address 0. A segment is the control word, count, destination and code words, at consecutive addresses, and the next segment starts right after the last code word. Control bit 0 = 1 means another segment follows; bit 0 = 0 ends the load, and the other control bits are ignored. `mbx_rd_en` stays low.
- R5: Read data is valid the cycle after the request. Code word k of a segment is written to destination + k (modulo 2^16) in the cycle after its read, with a throughput of one word per cycle.
- R6: A count of zero writes nothing, and the sequencer moves on to the next segment or to handoff.
- R7: `src_in_pspace` is high from the first cycle after the sampling edge in EPROM mode through the handoff cycle. It is low in every other case and during reset.
- R8: `handoff` is a single-cycle pulse that occurs exactly once after each reset, in the cycle after the last copy step.
- R9: `busy` is high exactly during header and copy cycles. `pram_we` is never high while `busy` is low, and all outputs are low during reset.
- R10: Each header word takes two cycles (request, then capture). A segment with n > 0 words takes n + 2 copy cycles, and one with n = 0 takes one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_load | input | 1 | Boot-load strap |
| strap_debug | input | 1 | Debugger strap |
| strap_eprom | input | 1 | EPROM-source strap |
| mbx_rd_en | output | 1 | Mailbox read request |
| mbx_addr | output | 16 | Mailbox read address |
| mbx_rd_data | input | 16 | Mailbox data, one cycle after request |
| rom_rd_en | output | 1 | Boot EPROM read request |
| rom_addr | output | 16 | Boot EPROM read address |
| rom_rd_data | input | 16 | EPROM data, one cycle after request |
| pram_we | output | 1 | Program RAM write enable |
| pram_addr | output | 16 | Program RAM write address |
| pram_wdata | output | 16 | Program RAM write data |
| src_in_pspace | output | 1 | EPROM mapped into program space |
| busy | output | 1 | Load in progress |
| handoff | output | 1 | One-cycle completion pulse |

## Verification
The load is tried with a multi-word mailbox image, a zero-count mailbox, and a three-segment EPROM chain. The chain has a zero-length middle segment, a final segment that wraps past address 0xFFFF, and control words with stray upper bits set. Together these separate correct segment chaining and pointer advance from off-by-one header or address errors. Strap patterns cover every decode class, including all three straps high and debug plus EPROM without load. After each sampling edge the straps are flipped, which shows that later strap values are ignored. Every cycle is compared against a behavioural timeline for both read enables, writes, busy, handoff and the mapping flag.

// File: rtl/sbl_pkg.sv
package sbl_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;

    typedef enum logic [1:0] {MODE_NONE, MODE_MBOX, MODE_EPROM} boot_mode_e;
    typedef enum logic [2:0] {ST_STRAP, ST_HDR_REQ, ST_HDR_CAP, ST_COPY,
                              ST_DONE, ST_HALT} seq_state_e;
    typedef enum logic [1:0] {FLD_CTRL, FLD_COUNT, FLD_DEST} hdr_field_e;

    typedef struct packed {
        logic              chain;
        logic [DATA_W-1:0] count;
        logic [ADDR_W-1:0] dest;
    } seg_hdr_t;

    // debug strap takes precedence over the EPROM strap
    function automatic boot_mode_e decode_straps(input logic load, input logic dbg,
                                                 input logic eprom);
        if (load && dbg)
            return MODE_MBOX;
        else if (load && eprom)
            return MODE_EPROM;
        return MODE_NONE;
    endfunction
endpackage

// File: rtl/sbl_strap_decode.sv
module sbl_strap_decode
    import sbl_pkg::*;
(
    input  logic       load,
    input  logic       dbg,
    input  logic       eprom,
    output boot_mode_e mode
);
    assign mode = decode_straps(load, dbg, eprom);
endmodule

// File: rtl/sbl_src_mux.sv
module sbl_src_mux
    import sbl_pkg::*;
(
    input  boot_mode_e        mode,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              mbx_rd_en,
    output logic [ADDR_W-1:0] mbx_addr,
    input  logic [DATA_W-1:0] mbx_rd_data,
    output logic              rom_rd_en,
    output logic [ADDR_W-1:0] rom_addr,
    input  logic [DATA_W-1:0] rom_rd_data
);
    logic sel_rom;
    assign sel_rom   = (mode == MODE_EPROM);
    assign mbx_rd_en = rd_req && (mode == MODE_MBOX);
    assign rom_rd_en = rd_req && sel_rom;
    assign mbx_addr  = (mode == MODE_MBOX) ? rd_addr : '0;
    assign rom_addr  = sel_rom ? rd_addr : '0;
    assign rd_data   = sel_rom ? rom_rd_data : mbx_rd_data;
endmodule

// File: rtl/sbl_ctrl.sv
module sbl_ctrl
    import sbl_pkg::*;
#(
    parameter logic [ADDR_W-1:0] MBOX_BASE = 16'hF400,
    parameter logic [ADDR_W-1:0] ROM_BASE  = 16'h0000
) (
    input  logic              clk,
    input  logic              rst,
    input  boot_mode_e        strap_mode,
    input  logic [DATA_W-1:0] rd_data,
    output boot_mode_e        mode,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              pram_we,
    output logic [ADDR_W-1:0] pram_addr,
    output logic [DATA_W-1:0] pram_wdata,
    output logic              busy,
    output logic              handoff,
    output logic              map_flag
);
    seq_state_e        st;
    boot_mode_e        mode_q;
    hdr_field_e        fld;
    seg_hdr_t          hdr;
    logic [ADDR_W-1:0] src_ptr;
    logic [DATA_W-1:0] rd_cnt;
    logic [DATA_W-1:0] wr_cnt;
    logic              pend;
    logic              map_q;
    logic              copy_end;

    always_comb begin
        rd_req     = (st == ST_HDR_REQ) || ((st == ST_COPY) && (rd_cnt != hdr.count));
        rd_addr    = src_ptr;
        pram_we    = (st == ST_COPY) && pend;
        pram_addr  = hdr.dest + ADDR_W'(wr_cnt);
        pram_wdata = rd_data;
        busy       = (st == ST_HDR_REQ) || (st == ST_HDR_CAP) || (st == ST_COPY);
        handoff    = (st == ST_DONE);
        copy_end   = (st == ST_COPY) && !rd_req && !pend;
    end

    assign mode     = mode_q;
    assign map_flag = map_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_STRAP;
            mode_q  <= MODE_NONE;
            fld     <= FLD_CTRL;
            hdr     <= '0;
            src_ptr <= '0;
            rd_cnt  <= '0;
            wr_cnt  <= '0;
            pend    <= 1'b0;
            map_q   <= 1'b0;
        end else begin
            case (st)
                ST_STRAP: begin
                    mode_q <= strap_mode;
                    case (strap_mode)
                        MODE_MBOX: begin
                            st      <= ST_HDR_REQ;
                            fld     <= FLD_COUNT;
                            src_ptr <= MBOX_BASE;
                        end
                        MODE_EPROM: begin
                            st      <= ST_HDR_REQ;
                            fld     <= FLD_CTRL;
                            src_ptr <= ROM_BASE;
                            map_q   <= 1'b1;
                        end
                        default: st <= ST_DONE;
                    endcase
                end
                ST_HDR_REQ: begin
                    src_ptr <= src_ptr + 1'b1;
                    st      <= ST_HDR_CAP;
                end
                ST_HDR_CAP: begin
                    case (fld)
                        FLD_CTRL: begin
                            hdr.chain <= rd_data[0];
                            fld       <= FLD_COUNT;
                            st        <= ST_HDR_REQ;
                        end
                        FLD_COUNT: begin
                            hdr.count <= rd_data;
                            fld       <= FLD_DEST;
                            st        <= ST_HDR_REQ;
                        end
                        default: begin
                            hdr.dest <= ADDR_W'(rd_data);
                            rd_cnt   <= '0;
                            wr_cnt   <= '0;
                            pend     <= 1'b0;
                            st       <= ST_COPY;
                        end
                    endcase
                end
                ST_COPY: begin
                    if (rd_req) begin
                        src_ptr <= src_ptr + 1'b1;
                        rd_cnt  <= rd_cnt + 1'b1;
                    end
                    if (pend)
                        wr_cnt <= wr_cnt + 1'b1;
                    pend <= rd_req;
                    if (copy_end) begin
                        if ((mode_q == MODE_EPROM) && hdr.chain) begin
                            fld <= FLD_CTRL;
                            st  <= ST_HDR_REQ;
                        end else begin
                            st <= ST_DONE;
                        end
                    end
                end
                ST_DONE: begin
                    map_q <= 1'b0;
                    st    <= ST_HALT;
                end
                default: st <= ST_HALT;
            endcase
        end
    end
endmodule

// File: rtl/strap_boot_loader.sv
module strap_boot_loader
    import sbl_pkg::*;
#(
    parameter logic [ADDR_W-1:0] MBOX_BASE = 16'hF400,
    parameter logic [ADDR_W-1:0] ROM_BASE  = 16'h0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strap_load,
    input  logic              strap_debug,
    input  logic              strap_eprom,
    output logic              mbx_rd_en,
    output logic [ADDR_W-1:0] mbx_addr,
    input  logic [DATA_W-1:0] mbx_rd_data,
    output logic              rom_rd_en,
    output logic [ADDR_W-1:0] rom_addr,
    input  logic [DATA_W-1:0] rom_rd_data,
    output logic              pram_we,
    output logic [ADDR_W-1:0] pram_addr,
    output logic [DATA_W-1:0] pram_wdata,
    output logic              src_in_pspace,
    output logic              busy,
    output logic              handoff
);
    boot_mode_e        strap_mode;
    boot_mode_e        mode;
    logic              rd_req;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;

    sbl_strap_decode u_dec (
        .load  (strap_load),
        .dbg   (strap_debug),
        .eprom (strap_eprom),
        .mode  (strap_mode)
    );

    sbl_ctrl #(.MBOX_BASE(MBOX_BASE), .ROM_BASE(ROM_BASE)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .strap_mode (strap_mode),
        .rd_data    (rd_data),
        .mode       (mode),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .pram_we    (pram_we),
        .pram_addr  (pram_addr),
        .pram_wdata (pram_wdata),
        .busy       (busy),
        .handoff    (handoff),
        .map_flag   (src_in_pspace)
    );

    sbl_src_mux u_mux (
        .mode        (mode),
        .rd_req      (rd_req),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .mbx_rd_en   (mbx_rd_en),
        .mbx_addr    (mbx_addr),
        .mbx_rd_data (mbx_rd_data),
        .rom_rd_en   (rom_rd_en),
        .rom_addr    (rom_addr),
        .rom_rd_data (rom_rd_data)
    );
endmodule

// File: rtl/sbl_checker.sv
module sbl_checker (
    input logic clk,
    input logic rst,
    input logic mbx_rd_en,
    input logic rom_rd_en,
    input logic pram_we,
    input logic busy,
    input logic handoff,
    input logic src_in_pspace
);
    logic seen_handoff;
    always_ff @(posedge clk) begin
        if (rst)
            seen_handoff <= 1'b0;
        else if (handoff)
            seen_handoff <= 1'b1;
    end

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        handoff |=> !handoff);
    a_r8_only_once: assert property (@(posedge clk) disable iff (rst)
        handoff |-> !seen_handoff);
    a_r9_write_while_busy: assert property (@(posedge clk) disable iff (rst)
        pram_we |-> busy);
    a_r9_idle_after_handoff: assert property (@(posedge clk) disable iff (rst)
        handoff |=> (!busy && !pram_we));
    a_r3_one_source: assert property (@(posedge clk) disable iff (rst)
        !(mbx_rd_en && rom_rd_en));
    a_r5_write_after_read: assert property (@(posedge clk) disable iff (rst)
        pram_we |-> $past(mbx_rd_en || rom_rd_en));
    a_r7_map_not_mailbox: assert property (@(posedge clk) disable iff (rst)
        src_in_pspace |-> !mbx_rd_en);
    a_r8_handoff_not_busy: assert property (@(posedge clk) disable iff (rst)
        handoff |-> !busy);
endmodule

bind strap_boot_loader sbl_checker u_sbl_checker (
    .clk           (clk),
    .rst           (rst),
    .mbx_rd_en     (mbx_rd_en),
    .rom_rd_en     (rom_rd_en),
    .pram_we       (pram_we),
    .busy          (busy),
    .handoff       (handoff),
    .src_in_pspace (src_in_pspace)
);

// File: tb/strap_boot_loader_test.sv
module strap_boot_loader_test;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic        we;
        logic [15:0] addr;
        logic [15:0] data;
        logic        busy;
        logic        ho;
        logic        map;
        logic        mrd;
        logic        rrd;
    } cyc_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic s_load = 1'b0, s_dbg = 1'b0, s_eprom = 1'b0;
    logic        mbx_rd_en, rom_rd_en, pram_we, src_in_pspace, busy, handoff;
    logic [15:0] mbx_addr, rom_addr, pram_addr, pram_wdata;
    logic [15:0] mbx_q = '0, rom_q = '0;
    logic [15:0] mbx_mem [0:63];
    logic [15:0] rom_mem [0:255];
    cyc_t        exp_q[$];
    int          vectors = 0;
    int          miscompares = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    strap_boot_loader uut (
        .clk(clk), .rst(rst),
        .strap_load(s_load), .strap_debug(s_dbg), .strap_eprom(s_eprom),
        .mbx_rd_en(mbx_rd_en), .mbx_addr(mbx_addr), .mbx_rd_data(mbx_q),
        .rom_rd_en(rom_rd_en), .rom_addr(rom_addr), .rom_rd_data(rom_q),
        .pram_we(pram_we), .pram_addr(pram_addr), .pram_wdata(pram_wdata),
        .src_in_pspace(src_in_pspace), .busy(busy), .handoff(handoff)
    );

    // synchronous-read source memories
    always @(posedge clk) begin
        if (mbx_rd_en) mbx_q <= mbx_mem[6'(mbx_addr - 16'hF400)];
        if (rom_rd_en) rom_q <= rom_mem[8'(rom_addr)];
    end

    function automatic cyc_t idle_cyc();
        cyc_t c;
        c.we = 0; c.addr = '0; c.data = '0; c.busy = 0;
        c.ho = 0; c.map = 0; c.mrd = 0; c.rrd = 0;
        return c;
    endfunction

    // expected cycles of one segment: header fields then the copy
    task automatic add_segment(input bit is_rom, input int hdr_words, input logic [15:0] cnt,
                               input logic [15:0] dst, input int code_at);
        cyc_t c;
        for (int h = 0; h < hdr_words; h++) begin
            c = idle_cyc(); c.busy = 1; c.map = is_rom; c.mrd = !is_rom; c.rrd = is_rom;
            exp_q.push_back(c);
            c = idle_cyc(); c.busy = 1; c.map = is_rom;
            exp_q.push_back(c);
        end
        if (cnt == 0) begin
            c = idle_cyc(); c.busy = 1; c.map = is_rom;
            exp_q.push_back(c);
        end else begin
            for (int k = 0; k <= int'(cnt) + 1; k++) begin
                c = idle_cyc(); c.busy = 1; c.map = is_rom;
                if (k < int'(cnt)) begin c.mrd = !is_rom; c.rrd = is_rom; end
                if (k >= 1 && k <= int'(cnt)) begin
                    c.we   = 1;
                    c.addr = dst + 16'(k - 1);
                    c.data = is_rom ? rom_mem[code_at + k - 1] : mbx_mem[code_at + k - 1];
                end
                exp_q.push_back(c);
            end
        end
    endtask

    task automatic build_expect(input logic b, input logic d, input logic r);
        cyc_t c;
        exp_q.delete();
        if (b && d) begin
            add_segment(0, 2, mbx_mem[0], mbx_mem[1], 2);
        end else if (b && r && !d) begin
            int ptr = 0;
            bit more = 1;
            while (more) begin
                add_segment(1, 3, rom_mem[ptr+1], rom_mem[ptr+2], ptr + 3);
                more = rom_mem[ptr][0];
                ptr  = ptr + 3 + int'(rom_mem[ptr+1]);
            end
        end
        c = idle_cyc(); c.ho = 1; c.map = (b && r && !d);
        exp_q.push_back(c);
        for (int i = 0; i < 5; i++) exp_q.push_back(idle_cyc());
    endtask

    task automatic cmp1(input string tag, input string what, input logic act, input logic exp);
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic cmp16(input string tag, input string what, input logic [15:0] act,
                         input logic [15:0] exp);
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic run_case(input logic b, input logic d, input logic r);
        rst = 1'b1;
        s_load = b; s_dbg = d; s_eprom = r;
        build_expect(b, d, r);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        vectors++;
        cmp1("R9", "busy in reset", busy, 1'b0);
        cmp1("R9", "we in reset", pram_we, 1'b0);
        cmp1("R8", "handoff in reset", handoff, 1'b0);
        cmp1("R7", "map in reset", src_in_pspace, 1'b0);
        rst = 1'b0;
        @(posedge clk);                 // sampling edge
        foreach (exp_q[i]) begin
            @(negedge clk);
            if (i == 0) begin           // R1: later strap changes ignored
                s_load = ~b; s_dbg = ~d; s_eprom = ~r;
            end
            vectors++;
            cmp1("R3", "mbx_rd_en", mbx_rd_en, exp_q[i].mrd);
            cmp1("R4", "rom_rd_en", rom_rd_en, exp_q[i].rrd);
            cmp1("R5", "pram_we", pram_we, exp_q[i].we);
            if (exp_q[i].we) begin
                cmp16("R5", "pram_addr", pram_addr, exp_q[i].addr);
                cmp16("R5", "pram_wdata", pram_wdata, exp_q[i].data);
            end
            cmp1("R9", "busy", busy, exp_q[i].busy);
            cmp1("R8", "handoff", handoff, exp_q[i].ho);
            cmp1("R7", "src_in_pspace", src_in_pspace, exp_q[i].map);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mbx_mem[i] = 16'hA000 + 16'(i * 7);
        for (int i = 0; i < 256; i++) rom_mem[i] = 16'h5000 + 16'(i * 3);
        // R3 mailbox image: 5 words to 0x0100
        mbx_mem[0] = 16'd5; mbx_mem[1] = 16'h0100;
        // R4 EPROM chain: ctrl/count/dest/code; R6 empty middle; R5 wrap in last
        rom_mem[0] = 16'h8001; rom_mem[1] = 16'd3; rom_mem[2] = 16'h0200;
        rom_mem[6] = 16'h0003; rom_mem[7] = 16'd0; rom_mem[8] = 16'h0300;
        rom_mem[9] = 16'hFFFE; rom_mem[10] = 16'd4; rom_mem[11] = 16'hFFFE;

        run_case(1, 1, 0);   // R2 R3 debugger mode
        run_case(1, 0, 1);   // R2 R4 R6 R10 EPROM chain
        run_case(1, 1, 1);   // R2 debug wins over EPROM strap
        run_case(1, 0, 0);   // R2 no valid mode
        run_case(0, 1, 1);   // R2 no load strap
        run_case(0, 0, 0);   // R2 R1 all low
        mbx_mem[0] = 16'd0; mbx_mem[1] = 16'h0400;
        run_case(1, 1, 0);   // R6 zero-count mailbox

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule